// File: doc/BRIEF.md
# Buffered SPI Master Shift Engine

This block drives a serial peripheral bus as the clock master. Software places data words into an eight-entry transmit queue through a small register port. Each word carries an end-of-transfer marker. A start command begins the transfer. The engine shifts each word out on the data-out pin and captures the incoming bits into a receive queue. It keeps going until it has shifted a word that carries the marker. Word length, clock rest level, capture edge and bit order are set in a configuration register. That register can only be written while the block is disabled.

Three sticky event flags record progress and trouble: transfer complete, transmit starvation and receive overflow. The interrupt output is the OR of the flags that are enabled in a mask register. If the transmit queue runs dry before a marked word, the engine parks with the clock at rest. It waits until software refills the queue, clears the starvation flag and starts again. A self-clearing control bit empties both queues. An internal loopback path routes the outgoing bit stream to the capture logic.

Top module: `spi_fifo_master`

Register map (3-bit `addr`):

| Addr | Name | Contents |
|------|------|----------|
| 0 | CTRL | bit 0 enable (read/write); bit 1 start (write only, reads 0); bit 2 queue flush (self-clearing) |
| 1 | CFG | bits 4:0 word length; bit 5 clock rest level; bit 6 capture on leading edge; bit 7 LSB first; bit 8 loopback; bits 15:9 half-period minus one, in clocks |
| 2 | MASK | bits 2:0, one enable per event |
| 3 | EVENT | bit 0 done; bit 1 transmit starvation; bit 2 receive overflow; write 1 to clear |
| 4 | STATUS | bit 0 ready; bit 1 receive queue empty; bit 2 transmit queue full; bit 3 interrupt pending; bit 4 busy |
| 5 | DATA | write: bits 23:0 data, bit 24 end marker, pushed to the transmit queue; read: head of the receive queue, popped when `rd_en` is high |

## Requirements
- R1: A CFG write takes effect only when bits 4:0 hold a value from 4 to 24. Any other value leaves the whole register unchanged. The reset value of CFG is 0x008.
- R2: CFG writes are ignored while CTRL bit 0 is 1. STATUS bit 0 (ready) becomes 1 in the cycle after the enable is set and is 0 while the enable is clear.
- R3: `sclk` rests at the level of CFG bit 5 whenever no word is being shifted.
- R4: When CFG bit 6 is 1, each bit is driven before the leading clock edge and captured on that edge. When it is 0, each bit is driven on the leading edge and captured on the trailing edge.
- R5: CFG bit 7 set shifts bit 0 of each word first. When it is clear, the bit at position length-1 goes first.
- R6: Each received word sits right-aligned in DATA reads, with zeros above the configured length.
- R7: After a word written with DATA bit 24 set has been shifted, EVENT bit 0 is set and the engine stops without popping further words.
- R8: If the transmit queue is empty when the next word is due and no marked word has been sent, EVENT bit 1 is set. The engine then holds `sclk` at rest and stays busy. It resumes only after EVENT bit 1 is cleared, the queue is non-empty and a start is written.
- R9: A word completed while the receive queue holds 8 entries sets EVENT bit 2 and is discarded. The 8 stored words are kept.
- R10: Writing 1 to an EVENT bit clears it. `irq` and STATUS bit 3 equal the OR of the EVENT bits whose MASK bits are set.
- R11: Writing CTRL bit 2 empties both queues. CTRL bit 2 reads 0 once the flush is finished.
- R12: A start written while the transmit queue is empty is ignored, and busy stays 0.
- R13: STATUS bit 1 reports an empty receive queue and STATUS bit 2 reports a full transmit queue (8 entries).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (pops the receive queue at DATA) |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Masked event interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The main data path is exercised in all four combinations of clock rest level and capture edge. The tests cover word lengths of 4, 8, 13 and 24 bits, with both bit orders and varied bit patterns. A monitor rebuilds each word from the pins at the edge the configuration selects, so a wrong capture edge or a reversed bit order shows up at the pins as well as in the looped-back receive data. One run turns loopback off and holds `miso` at 1, which separates correct right alignment and zero fill from leftover bits above the word length. Further runs starve the transmit queue in mid-transfer and overfill the receive queue, to tell a paused clock apart from a running one and a dropped word apart from an overwritten one.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   localparam int LEN_W     = 5;
   localparam int DIV_W     = 7;
   localparam int MIN_WLEN  = 4;
   localparam int DEF_WLEN  = 8;
   localparam int NUM_EV    = 3;

   localparam int EV_DONE   = 0;
   localparam int EV_STARVE = 1;
   localparam int EV_OVER   = 2;

   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_CFG    = 3'd1;
   localparam logic [2:0] A_MASK   = 3'd2;
   localparam logic [2:0] A_EVENT  = 3'd3;
   localparam logic [2:0] A_STATUS = 3'd4;
   localparam logic [2:0] A_DATA   = 3'd5;

   typedef struct packed {
      logic [DIV_W-1:0] half_div;
      logic             loopback;
      logic             lsb_first;
      logic             cap_lead;
      logic             rest_hi;
      logic [LEN_W-1:0] wlen;
   } spi_cfg_t;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_LOAD  = 2'd1,
      SH_SHIFT = 2'd2,
      SH_PARK  = 2'd3
   } sh_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
   parameter int W     = 25,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_word_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end

   // a push into a full queue must not disturb what is stored (R9)
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (cnt == $past(cnt)));

   // flush leaves the queue empty on the next cycle (R11)
   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
   import spi_eng_pkg::*;
#(
   parameter int MAXW = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_ok,
   input  logic            start,
   input  spi_cfg_t        cfg,
   input  logic            tx_empty,
   input  logic [MAXW:0]   tx_word,
   input  logic            starve_flag,
   input  logic            miso,
   output logic            tx_pop,
   output logic            rx_push,
   output logic [MAXW-1:0] rx_word,
   output logic            done_p,
   output logic            starve_p,
   output logic            busy,
   output logic            sclk,
   output logic            mosi
);
   sh_state_t         state;
   logic [DIV_W-1:0]  tick_cnt;
   logic              half_b;
   logic [LEN_W-1:0]  idx;
   logic [MAXW-1:0]   shreg;
   logic [MAXW-1:0]   rxacc;
   logic              last_q;
   logic              out_bit;
   logic              sclk_q;
   logic              miso_in;
   logic              tick;
   logic              end_word;

   function automatic logic [LEN_W-1:0] bpos(input logic [LEN_W-1:0] i);
      return cfg.lsb_first ? i : LEN_W'(cfg.wlen - LEN_W'(1) - i);
   endfunction

   assign miso_in  = cfg.loopback ? out_bit : miso;
   assign tick     = (tick_cnt == cfg.half_div);
   assign end_word = (state == SH_SHIFT) && tick && half_b && (idx == cfg.wlen - LEN_W'(1));
   assign tx_pop   = (state == SH_LOAD) && !tx_empty;
   assign starve_p = (state == SH_LOAD) && tx_empty;
   assign rx_push  = end_word;
   assign done_p   = end_word && last_q;
   assign busy     = (state != SH_IDLE);
   assign sclk     = sclk_q;
   assign mosi     = out_bit;

   always_comb begin
      rx_word = rxacc;
      if (!cfg.cap_lead) rx_word[bpos(idx)] = miso_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SH_IDLE;
         tick_cnt <= '0;
         half_b   <= 1'b0;
         idx      <= '0;
         shreg    <= '0;
         rxacc    <= '0;
         last_q   <= 1'b0;
         out_bit  <= 1'b0;
         sclk_q   <= 1'b0;
      end else if (!run_ok) begin
         state    <= SH_IDLE;
         tick_cnt <= '0;
         half_b   <= 1'b0;
         sclk_q   <= cfg.rest_hi;
      end else begin
         case (state)
            SH_IDLE: begin
               sclk_q <= cfg.rest_hi;
               if (start && !tx_empty) state <= SH_LOAD;
            end
            SH_LOAD: begin
               sclk_q <= cfg.rest_hi;
               if (!tx_empty) begin
                  shreg    <= tx_word[MAXW-1:0];
                  last_q   <= tx_word[MAXW];
                  idx      <= '0;
                  half_b   <= 1'b0;
                  tick_cnt <= '0;
                  rxacc    <= '0;
                  if (cfg.cap_lead) out_bit <= tx_word[bpos('0)];
                  state    <= SH_SHIFT;
               end else begin
                  state <= SH_PARK;
               end
            end
            SH_PARK: begin
               sclk_q <= cfg.rest_hi;
               if (start && !starve_flag && !tx_empty) state <= SH_LOAD;
            end
            default: begin
               if (!tick) begin
                  tick_cnt <= tick_cnt + 1'b1;
               end else begin
                  tick_cnt <= '0;
                  if (!half_b) begin
                     half_b <= 1'b1;
                     sclk_q <= ~cfg.rest_hi;
                     if (cfg.cap_lead) rxacc[bpos(idx)] <= miso_in;
                     else              out_bit <= shreg[bpos(idx)];
                  end else begin
                     half_b <= 1'b0;
                     sclk_q <= cfg.rest_hi;
                     if (!cfg.cap_lead) rxacc[bpos(idx)] <= miso_in;
                     if (idx == cfg.wlen - LEN_W'(1)) begin
                        state <= last_q ? SH_IDLE : SH_LOAD;
                     end else begin
                        idx <= idx + 1'b1;
                        if (cfg.cap_lead) out_bit <= shreg[bpos(LEN_W'(idx + 1'b1))];
                     end
                  end
               end
            end
         endcase
      end
   end

   // clock rests at the configured level while idle (R3)
   assert_idle_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_IDLE && $past(state == SH_IDLE) && $stable(cfg.rest_hi))
      |-> (sclk_q == cfg.rest_hi));

   // the marked word ends the transfer (R7)
   assert_done_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |=> (state == SH_IDLE));

   // starvation parks the engine (R8)
   assert_starve_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (starve_p && run_ok) |=> (state == SH_PARK));

   // no clock activity while parked (R8)
   assert_park_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SH_PARK && $past(state == SH_PARK)) |-> $stable(sclk_q));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spi_eng_pkg::*;
#(
   parameter int MAXW  = 24,
   parameter int DEPTH = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  addr,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   input  logic        rd_en,
   output logic [31:0] rdata,
   output logic        irq,
   output logic        sclk,
   output logic        mosi,
   input  logic        miso
);
   generate
      if (MAXW < MIN_WLEN || MAXW > 31 || MAXW >= (1 << LEN_W)) begin : g_bad_maxw
         $error("spi_fifo_master: MAXW out of range");
      end
   endgenerate

   spi_cfg_t          cfg_q;
   logic              en_q, ready_q, flush_q;
   logic [NUM_EV-1:0] mask_q, ev_q, ev_set, ev_clr;
   logic              wr_ctrl, wr_cfg, start_p, len_ok;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic              tx_pop, rx_push, done_p, starve_p, busy;
   logic [MAXW:0]     tx_word;
   logic [MAXW-1:0]   rx_word, rx_head;
   logic              unused_wdata;

   assign unused_wdata = &{1'b0, wdata[31:MAXW+1]};
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_cfg  = wr_en && (addr == A_CFG);
   assign start_p = wr_ctrl && wdata[1];
   assign len_ok  = (wdata[LEN_W-1:0] >= LEN_W'(MIN_WLEN)) && (wdata[LEN_W-1:0] <= LEN_W'(MAXW));
   assign ev_clr  = (wr_en && addr == A_EVENT) ? wdata[NUM_EV-1:0] : '0;

   always_comb begin
      ev_set            = '0;
      ev_set[EV_DONE]   = done_p;
      ev_set[EV_STARVE] = starve_p;
      ev_set[EV_OVER]   = rx_push && rx_full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         ready_q <= 1'b0;
         flush_q <= 1'b0;
         mask_q  <= '0;
         ev_q    <= '0;
         cfg_q   <= '{half_div: '0, loopback: 1'b0, lsb_first: 1'b0,
                      cap_lead: 1'b0, rest_hi: 1'b0, wlen: LEN_W'(DEF_WLEN)};
      end else begin
         ready_q <= en_q;
         flush_q <= wr_ctrl && wdata[2];
         if (wr_ctrl) en_q <= wdata[0];
         if (wr_cfg && !en_q && len_ok) cfg_q <= spi_cfg_t'(wdata[$bits(spi_cfg_t)-1:0]);
         if (wr_en && addr == A_MASK) mask_q <= wdata[NUM_EV-1:0];
         ev_q <= (ev_q & ~ev_clr) | ev_set;
      end
   end

   assign irq = |(ev_q & mask_q);

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:   rdata = {29'd0, flush_q, 1'b0, en_q};
         A_CFG:    rdata = 32'(cfg_q);
         A_MASK:   rdata = 32'(mask_q);
         A_EVENT:  rdata = 32'(ev_q);
         A_STATUS: rdata = {27'd0, busy, irq, tx_full, rx_empty, ready_q};
         A_DATA:   rdata = 32'(rx_head);
         default:  rdata = '0;
      endcase
   end

   spi_word_fifo #(.W(MAXW + 1), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush_q),
      .push(wr_en && addr == A_DATA), .wdata(wdata[MAXW:0]),
      .pop(tx_pop), .rdata(tx_word), .empty(tx_empty), .full(tx_full));

   spi_word_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush_q),
      .push(rx_push), .wdata(rx_word),
      .pop(rd_en && addr == A_DATA), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

   spi_shift_core #(.MAXW(MAXW)) u_core (
      .clk(clk), .rst_n(rst_n), .run_ok(en_q && ready_q), .start(start_p),
      .cfg(cfg_q), .tx_empty(tx_empty), .tx_word(tx_word),
      .starve_flag(ev_q[EV_STARVE]), .miso(miso),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
      .done_p(done_p), .starve_p(starve_p), .busy(busy),
      .sclk(sclk), .mosi(mosi));

   // configuration is frozen while enabled (R2)
   assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q)) |-> $stable(cfg_q));

   // write-one-to-clear of the done flag (R10)
   assert_ev_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_EVENT && wdata[EV_DONE] && !done_p) |=> !ev_q[EV_DONE]);

   // a word arriving at a full receive queue raises the overflow flag (R9)
   assert_rx_over_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full) |=> ev_q[EV_OVER]);
endmodule

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic        irq, sclk, mosi;
   logic        miso = 1'b1;

   int total = 0;
   int bad = 0;
   int q_pin[$];
   int q_rx[$];
   int m_len = 8;
   logic m_rest = 1'b0, m_lead = 1'b0, m_lsb = 1'b0, m_lb = 1'b0;
   logic mon_on = 1'b0;
   logic prev_sclk = 1'b0;
   int mon_cnt = 0;
   logic [31:0] mon_acc = '0;

   spi_fifo_master uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso));

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = (a == 3'd5);
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [31:0] lmask();
      return (32'd1 << m_len) - 1;
   endfunction

   // pin monitor: rebuild each word at the selected capture edge (R4, R5)
   always @(negedge clk) begin
      if (rst_n && mon_on && sclk !== prev_sclk) begin
         if ((sclk != m_rest) == m_lead) begin
            mon_acc[m_lsb ? mon_cnt : m_len - 1 - mon_cnt] = mosi;
            mon_cnt++;
            if (mon_cnt == m_len) begin
               if (q_pin.size() > 0) check("R4 R5 pin word", mon_acc, q_pin.pop_front());
               else check("R4 R5 unexpected pin word", mon_acc, 32'hDEAD_0000);
               mon_cnt = 0;
               mon_acc = '0;
            end
         end
      end
      prev_sclk = sclk;
   end

   task automatic setup(input int len, input logic rest, input logic lead,
                        input logic lsb, input logic lb);
      mon_on = 1'b0;
      wr(3'd0, 32'd0);
      wr(3'd1, {16'd0, 7'd1, lb, lsb, lead, rest, 5'(len)});
      m_len = len; m_rest = rest; m_lead = lead; m_lsb = lsb; m_lb = lb;
      wr(3'd0, 32'd1);
      repeat (4) @(negedge clk);
      mon_cnt = 0; mon_acc = '0; mon_on = 1'b1;
   endtask

   task automatic push(input logic [31:0] d, input logic last);
      wr(3'd5, {7'd0, last, d[23:0]});
      q_pin.push_back(int'(d & lmask()));
      q_rx.push_back(int'(m_lb ? (d & lmask()) : (miso ? lmask() : 32'd0)));
   endtask

   task automatic wait_ev(input int b, input string tag);
      logic [31:0] v;
      for (int i = 0; i < 5000; i++) begin
         rd(3'd3, v);
         if (v[b]) return;
      end
      check(tag, 32'd0, 32'd1);
   endtask

   task automatic drain(input int n);
      logic [31:0] v;
      for (int i = 0; i < n; i++) begin
         rd(3'd5, v);
         check("R6 rx word", v, q_rx.pop_front());
      end
   endtask

   task automatic xfer3(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      wr(3'd3, 32'h7);
      push(a, 1'b0); push(b, 1'b0); push(c, 1'b1);
      wr(3'd0, 32'h3);
      wait_ev(0, "R7 done timeout");
      repeat (3) @(negedge clk);
      check("R3 sclk rest after transfer", {31'd0, sclk}, {31'd0, m_rest});
      drain(3);
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(3'd4, v); check("R13 status after reset", v, 32'h02);
      rd(3'd0, v); check("R2 ctrl after reset", v, 32'h0);
      rd(3'd1, v); check("R1 cfg reset value", v, 32'h008);
      check("R3 sclk at reset", {31'd0, sclk}, 32'd0);
      check("R10 irq at reset", {31'd0, irq}, 32'd0);

      // R1 length legality
      wr(3'd1, 32'h003); rd(3'd1, v); check("R1 length 3 rejected", v, 32'h008);
      wr(3'd1, 32'h039); rd(3'd1, v); check("R1 length 25 rejected", v, 32'h008);
      wr(3'd1, 32'h018); rd(3'd1, v); check("R1 length 24 accepted", v, 32'h018);

      // R2 enable, ready and frozen config
      wr(3'd0, 32'h1); rd(3'd4, v); check("R2 ready after enable", v & 32'h1, 32'h1);
      wr(3'd1, 32'h005); rd(3'd1, v); check("R2 cfg write ignored when enabled", v, 32'h018);

      // R12 start with empty queue
      wr(3'd0, 32'h3); rd(3'd4, v); check("R12 busy stays low", v & 32'h10, 32'h0);

      // main function under varied modes
      setup(8, 1'b0, 1'b1, 1'b0, 1'b1); xfer3(32'hA5, 32'h3C, 32'hF0);
      setup(8, 1'b1, 1'b0, 1'b1, 1'b1);
      check("R3 rest high before start", {31'd0, sclk}, 32'd1);
      xfer3(32'h81, 32'h7E, 32'h96);
      setup(13, 1'b0, 1'b0, 1'b1, 1'b1); xfer3(32'h1ABC, 32'h0123, 32'h1F0F);
      setup(24, 1'b1, 1'b1, 1'b0, 1'b1); xfer3(32'hABCDEF, 32'h123456, 32'h800001);
      setup(4, 1'b0, 1'b1, 1'b1, 1'b1); xfer3(32'h9, 32'h6, 32'hE);

      // R10 mask and write-one-to-clear
      check("R10 irq masked", {31'd0, irq}, 32'd0);
      wr(3'd2, 32'h1);
      check("R10 irq when unmasked", {31'd0, irq}, 32'd1);
      rd(3'd4, v); check("R10 status pending", v & 32'h8, 32'h8);
      wr(3'd3, 32'h1);
      check("R10 irq after clear", {31'd0, irq}, 32'd0);
      rd(3'd3, v); check("R10 event cleared", v, 32'h0);
      wr(3'd2, 32'h0);

      // R6 zero fill with external input held high
      setup(5, 1'b0, 1'b0, 1'b0, 1'b0);
      miso = 1'b1;
      xfer3(32'h15, 32'h0A, 32'hFF);

      // R8 starvation pause and resume
      setup(8, 1'b1, 1'b1, 1'b0, 1'b1);
      wr(3'd3, 32'h7);
      push(32'h5A, 1'b0); push(32'hC3, 1'b0);
      wr(3'd0, 32'h3);
      wait_ev(1, "R8 starvation timeout");
      rd(3'd4, v); check("R8 busy while parked", v & 32'h10, 32'h10);
      check("R8 sclk at rest while parked", {31'd0, sclk}, 32'd1);
      repeat (20) @(negedge clk);
      check("R8 sclk still at rest", {31'd0, sclk}, 32'd1);
      rd(3'd3, v); check("R8 no done while parked", v & 32'h1, 32'h0);
      push(32'h3F, 1'b1);
      wr(3'd3, 32'h2);
      wr(3'd0, 32'h3);
      wait_ev(0, "R8 resume done timeout");
      drain(3);

      // R9 receive overflow and R13 full flag
      setup(8, 1'b0, 1'b0, 1'b0, 1'b1);
      wr(3'd3, 32'h7);
      for (int i = 0; i < 8; i++) push(32'h10 + i, 1'b0);
      rd(3'd4, v); check("R13 tx full", v & 32'h4, 32'h4);
      wr(3'd0, 32'h3);
      repeat (4) @(negedge clk);
      push(32'hEE, 1'b1);
      void'(q_rx.pop_back());
      wait_ev(0, "R9 done timeout");
      rd(3'd3, v); check("R9 overflow flag", v & 32'h4, 32'h4);
      rd(3'd4, v); check("R13 rx not empty", v & 32'h2, 32'h0);
      drain(8);
      rd(3'd4, v); check("R9 only eight kept", v & 32'h2, 32'h2);

      // R11 flush of both queues
      wr(3'd3, 32'h7);
      push(32'h42, 1'b1);
      wr(3'd0, 32'h3);
      wait_ev(0, "R11 setup done timeout");
      push(32'h11, 1'b0); push(32'h22, 1'b0);
      rd(3'd4, v); check("R11 rx holds word before flush", v & 32'h2, 32'h0);
      wr(3'd0, 32'h5);
      q_pin.delete(); q_rx.delete();
      rd(3'd0, v); check("R11 ctrl reads back", v, 32'h1);
      rd(3'd4, v); check("R11 queues empty", v & 32'h6, 32'h2);
      wr(3'd0, 32'h3);
      repeat (10) @(negedge clk);
      rd(3'd4, v); check("R11 R12 nothing to shift", v & 32'h10, 32'h0);

      check("R7 all words shifted", q_pin.size(), 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule